// File: doc/BRIEF.md
# Per-Core Reset Cause and Pin Event Status

This block keeps a record, for a cluster of eight processor cores, of what caused the most recent reset and of which cores have seen a local-reset or non-maskable-interrupt request on their pins. It watches three kinds of asynchronous request lines: one device-wide reset request, one local-reset request per core and one NMI request per core. Each line passes through a two-flop synchroniser and a rising-edge detector, so that each assertion of a line counts as exactly one event.

Two words are held. The first is the pin-event word. It has a sticky flag per core for local-reset requests and a second sticky flag per core for NMI requests. Software clears these flags by writing ones to a companion clear address. The second word is the reset-cause word. It holds one global-cause bit and one local-cause bit per core, and the global and local causes exclude each other. Boot software reads the reset-cause word to choose between a full device start-up and a core-only restart. It reads and clears the pin-event word to acknowledge requests.

Access is through a single-cycle register port. The port has an address, a write strobe, write data and combinational read data. The whole block is cleared by a power-on reset, which is separate from the device-wide reset request it records.

Top module: `rst_cause_regs`

## Requirements
- R1: After power-on reset the pin-event word reads 0x0000_0000 at both 0x0 and 0x4. The reset-cause word reads 0x8000_0000 at 0x8, with the global-cause bit set and all local-cause bits clear.
- R2: Reads decode three addresses. 0x0 returns the pin-event word. 0x4 also returns the current pin-event word. 0x8 returns the reset-cause word. Any other address returns zero.
- R3: A rising edge on the local-reset request of core n sets pin-event bit n. The flag is set on the third rising clock edge after the input rises, and not earlier.
- R4: A rising edge on the NMI request of core n sets pin-event bit n+8.
- R5: A write to 0x4 clears each pin-event flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R6: Bits 31:16 of the pin-event word always read as zero. Write-data bits 31:16 of a write to 0x4 have no effect.
- R7: If a new event and a clear write reach the same pin-event flag on the same clock edge, the flag ends up set.
- R8: A local-reset event on core n with no global-reset event on the same edge sets local-cause bit n (bit n of the word at 0x8). It also clears the global-cause bit (bit 31). The other local-cause bits keep their values.
- R9: A global-reset event clears all local-cause bits and sets the global-cause bit. This also applies when local-reset events arrive on the same edge.
- R10: Bus writes to 0x0 and to 0x8 change neither word.
- R11: Events are edge-triggered. A request line held high sets its flag once, and after that flag is cleared it stays clear while the line remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| glb_rst_req | input | 1 | Asynchronous device-wide reset request |
| lrst_req | input | NCORES | Asynchronous per-core local-reset requests |
| nmi_req | input | NCORES | Asynchronous per-core NMI requests |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
A corrupted synchroniser or edge-detector stage shows up as a pin-event flag that appears one edge too early or too late. It can also show up as a flag that sets again while its request is held high, which a read of 0x0 exposes right after the third edge or after a clear. A wrong next-state priority in the reset-cause word shows up on the first read of 0x8 after an event. Examples are a global bit left set beside a local bit, or local bits that survive a global request. A misordered clear-versus-set merge is visible on the read that follows the single edge where a clear write and an arriving event coincide.

// File: rtl/rst_cause_regs.sv
module rst_cause_regs #(
  parameter int NCORES = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              glb_rst_req,
  input  logic [NCORES-1:0] lrst_req,
  input  logic [NCORES-1:0] nmi_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int PIN_W = 2 * NCORES;
  localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(4'h8);

  logic [NCORES-1:0] lr_s1, lr_s2, lr_q;
  logic [NCORES-1:0] nm_s1, nm_s2, nm_q;
  logic              gr_s1, gr_s2, gr_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lr_s1 <= '0; lr_s2 <= '0; lr_q <= '0;
      nm_s1 <= '0; nm_s2 <= '0; nm_q <= '0;
      gr_s1 <= 1'b0; gr_s2 <= 1'b0; gr_q <= 1'b0;
    end else begin
      lr_s1 <= lrst_req; lr_s2 <= lr_s1; lr_q <= lr_s2;
      nm_s1 <= nmi_req;  nm_s2 <= nm_s1; nm_q <= nm_s2;
      gr_s1 <= glb_rst_req; gr_s2 <= gr_s1; gr_q <= gr_s2;
    end
  end

  logic [NCORES-1:0] lr_pulse, nmi_pulse;
  logic              gr_pulse;
  assign lr_pulse  = lr_s2 & ~lr_q;
  assign nmi_pulse = nm_s2 & ~nm_q;
  assign gr_pulse  = gr_s2 & ~gr_q;

  logic [PIN_W-1:0] pin_stat, set_vec, clr_vec;
  assign set_vec = {nmi_pulse, lr_pulse};
  assign clr_vec = (bus_we && bus_addr == A_CLR) ? bus_wdata[PIN_W-1:0] : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pin_stat <= '0;
    else        pin_stat <= (pin_stat & ~clr_vec) | set_vec;
  end

  logic [NCORES-1:0] lr_cause;
  logic              gr_cause;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lr_cause <= '0;
      gr_cause <= 1'b1;
    end else if (gr_pulse) begin
      lr_cause <= '0;
      gr_cause <= 1'b1;
    end else if (|lr_pulse) begin
      lr_cause <= lr_cause | lr_pulse;
      gr_cause <= 1'b0;
    end
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[31:PIN_W];

  always_comb begin
    case (bus_addr)
      A_PIN, A_CLR: bus_rdata = {{(32-PIN_W){1'b0}}, pin_stat};
      A_RST:        bus_rdata = {gr_cause, {(31-NCORES){1'b0}}, lr_cause};
      default:      bus_rdata = '0;
    endcase
  end
endmodule

module rst_cause_regs_chk #(
  parameter int NCORES = 8,
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  por_n,
  input logic                  gr_pulse,
  input logic [NCORES-1:0]     lr_pulse,
  input logic [NCORES-1:0]     nmi_pulse,
  input logic [2*NCORES-1:0]   pin_stat,
  input logic [NCORES-1:0]     lr_cause,
  input logic                  gr_cause,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata
);
  localparam int PIN_W = 2 * NCORES;
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(4'h8);

  logic [PIN_W-1:0] ev;
  assign ev = {nmi_pulse, lr_pulse};

  assert_event_sets_flag_R3: assert property (@(posedge clk) disable iff (!por_n)
    (|ev) |=> ((pin_stat & $past(ev)) == $past(ev)));

  assert_clear_takes_effect_R5: assert property (@(posedge clk) disable iff (!por_n)
    (bus_we && bus_addr == A_CLR) |=> ((pin_stat & $past(bus_wdata[PIN_W-1:0] & ~ev)) == '0));

  assert_upper_reads_zero_R6: assert property (@(posedge clk) disable iff (!por_n)
    (bus_addr != A_RST) |-> (bus_rdata[31:PIN_W] == '0));

  assert_local_clears_global_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!gr_pulse && (|lr_pulse)) |=> (!gr_cause && ((lr_cause & $past(lr_pulse)) == $past(lr_pulse))));

  assert_global_clears_local_R9: assert property (@(posedge clk) disable iff (!por_n)
    gr_pulse |=> (gr_cause && lr_cause == '0));

  assert_causes_exclusive_R9: assert property (@(posedge clk) disable iff (!por_n)
    gr_cause |-> (lr_cause == '0));

  assert_cause_holds_R10: assert property (@(posedge clk) disable iff (!por_n)
    (!gr_pulse && lr_pulse == '0) |=> ($stable(lr_cause) && $stable(gr_cause)));
endmodule

bind rst_cause_regs rst_cause_regs_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por_n(por_n), .gr_pulse(gr_pulse), .lr_pulse(lr_pulse),
  .nmi_pulse(nmi_pulse), .pin_stat(pin_stat), .lr_cause(lr_cause),
  .gr_cause(gr_cause), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/rst_cause_regs_test.sv
module rst_cause_regs_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        glb_rst_req = 1'b0;
  logic [7:0]  lrst_req = '0;
  logic [7:0]  nmi_req = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_cause_regs uut (
    .clk(clk), .por_n(por_n), .glb_rst_req(glb_rst_req), .lrst_req(lrst_req),
    .nmi_req(nmi_req), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_we = 1'b0;
    bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic fire(input logic g, input logic [7:0] lr, input logic [7:0] nm);
    @(negedge clk);
    glb_rst_req = g; lrst_req = lr; nmi_req = nm;
    repeat (5) @(posedge clk);
    @(negedge clk);
    glb_rst_req = 1'b0; lrst_req = '0; nmi_req = '0;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 pin word", 4'h0, 32'h0);
    rd_chk("R1 clear addr", 4'h4, 32'h0);
    rd_chk("R1 cause word", 4'h8, 32'h8000_0000);
  endtask

  task automatic t_local;
    @(negedge clk);
    lrst_req[3] = 1'b1;
    repeat (2) @(posedge clk);
    rd_chk("R3 not before third edge", 4'h0, 32'h0);
    @(posedge clk);
    rd_chk("R3 set on third edge", 4'h0, 32'h0000_0008);
    @(negedge clk);
    lrst_req = '0;
    repeat (4) @(posedge clk);
    rd_chk("R8 local sets cause, clears global", 4'h8, 32'h0000_0008);
    fire(1'b0, 8'h20, 8'h00);
    rd_chk("R3 core5 flag", 4'h0, 32'h0000_0028);
    rd_chk("R8 other local bits kept", 4'h8, 32'h0000_0028);
  endtask

  task automatic t_addr;
    rd_chk("R2 clear addr mirrors pin word", 4'h4, 32'h0000_0028);
    rd_chk("R2 unmapped addr reads zero", 4'hC, 32'h0);
    rd_chk("R2 unmapped addr 0x2", 4'h2, 32'h0);
  endtask

  task automatic t_nmi;
    fire(1'b0, 8'h00, 8'h40);
    rd_chk("R4 nmi core6 at bit 14", 4'h0, 32'h0000_4028);
    fire(1'b0, 8'h00, 8'h01);
    rd_chk("R4 nmi core0 at bit 8", 4'h0, 32'h0000_4128);
    rd_chk("R4 nmi leaves cause word", 4'h8, 32'h0000_0028);
  endtask

  task automatic t_clear;
    wr(4'h4, 32'h0000_4008);
    rd_chk("R5 selected flags cleared", 4'h0, 32'h0000_0120);
    wr(4'h4, 32'h0);
    rd_chk("R5 zero write keeps flags", 4'h0, 32'h0000_0120);
  endtask

  task automatic t_upper;
    wr(4'h4, 32'hFFFF_0000);
    rd_chk("R6 upper clear bits ignored", 4'h0, 32'h0000_0120);
    rd_chk("R6 upper bits read zero at 0x4", 4'h4, 32'h0000_0120);
  endtask

  task automatic t_ro;
    wr(4'h8, 32'hFFFF_FFFF);
    rd_chk("R10 cause word ignores ones", 4'h8, 32'h0000_0028);
    wr(4'h8, 32'h0);
    rd_chk("R10 cause word ignores zeros", 4'h8, 32'h0000_0028);
    wr(4'h0, 32'hFFFF_FFFF);
    rd_chk("R10 pin word ignores write", 4'h0, 32'h0000_0120);
  endtask

  task automatic t_setwins;
    wr(4'h4, 32'h0000_FFFF);
    rd_chk("R5 clear all", 4'h0, 32'h0);
    @(negedge clk);
    lrst_req[1] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_addr = 4'h4; bus_wdata = 32'h0000_0002; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    lrst_req = '0;
    rd_chk("R7 set wins over clear", 4'h0, 32'h0000_0002);
    repeat (4) @(posedge clk);
    rd_chk("R8 cause adds core1", 4'h8, 32'h0000_002A);
  endtask

  task automatic t_global;
    fire(1'b1, 8'h00, 8'h00);
    rd_chk("R9 global clears local causes", 4'h8, 32'h8000_0000);
    rd_chk("R9 global leaves pin word", 4'h0, 32'h0000_0002);
    fire(1'b1, 8'h04, 8'h00);
    rd_chk("R9 global wins same edge", 4'h8, 32'h8000_0000);
    rd_chk("R3 pin flag still set with global", 4'h0, 32'h0000_0006);
    fire(1'b0, 8'h10, 8'h00);
    rd_chk("R8 local after global", 4'h8, 32'h0000_0010);
  endtask

  task automatic t_hold;
    wr(4'h4, 32'h0000_FFFF);
    @(negedge clk);
    nmi_req[7] = 1'b1;
    repeat (5) @(posedge clk);
    rd_chk("R11 held line sets flag", 4'h0, 32'h0000_8000);
    wr(4'h4, 32'h0000_8000);
    repeat (6) @(posedge clk);
    rd_chk("R11 held line does not reset flag", 4'h0, 32'h0);
    @(negedge clk);
    nmi_req = '0;
    repeat (4) @(posedge clk);
    rd_chk("R11 release makes no event", 4'h0, 32'h0);
    rd_chk("R10 cause unchanged by nmi", 4'h8, 32'h0000_0010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    por_n = 1'b1;
    t_reset();
    t_local();
    t_addr();
    t_nmi();
    t_clear();
    t_upper();
    t_ro();
    t_setwins();
    t_global();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule